// File: doc/BRIEF.md
# GPIO Controller with Edge-Event Interrupts

This block is a 32-line general-purpose I/O peripheral. Software reaches it through a simple register port. A write is taken on the clock edge when the write strobe is high. A read is combinational from the address in the same cycle. Each line can be an input or an output. An output line can be driven push-pull or open-drain. An input line reaches the data view only when its input buffer is enabled.

Every pin passes through a synchronizer. The synchronized value is compared against the previous sample to find edges. A per-line control bit picks whether only falling edges count or both edges count. Detected edges are latched into a sticky event register, which software clears by writing ones. A mask register selects which events drive the single interrupt output. Register bits are numbered opposite to line numbers: line 0 sits in the most significant bit. The pad vectors are indexed by line number.

Top module: `gpio_ctrl`

## Requirements
- R1: Line n occupies register bit 31−n in every register, so line 0 is bit 31. The pad vectors `pad_in`, `pad_out` and `pad_oe` are indexed by line (bit n is line n).
- R2: Registers are selected by byte address with the low two bits zero. 0x00 is direction, 0x04 is open-drain, 0x08 is data, 0x0C is event, 0x10 is mask, 0x14 is edge control and 0x18 is input enable. Direction, open-drain, mask, edge control and input enable read back what was written. Address 0x1C reads 0. A misaligned address reads 0 and ignores writes.
- R3: A direction bit of 1 makes the line an output and 0 makes it an input. A push-pull output line drives `pad_oe`=1 and `pad_out` equal to its data latch bit. An input line has `pad_oe`=0.
- R4: When a line's open-drain bit is 1, `pad_out` is 0. `pad_oe` is 1 only when the line is an output and its data latch is 0.
- R5: A data read returns the output latch for output lines. For input lines it returns the synchronized pin ANDed with that line's input enable bit. A pin change applied between edges shows in the read after the second following rising clock edge and not after the first.
- R6: Edge detection works on the synchronized pin whatever the direction and input enable. An edge-control bit of 0 lets rising and falling edges set the event bit. A bit of 1 lets only falling edges set it. The event bit is readable after the third rising edge that follows the pin change.
- R7: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. Writes can never set an event bit. If an edge is detected in the same cycle as the clearing write, the event bit stays set.
- R8: `irq` is 1 exactly when some bit of (event AND mask) is 1. Writing all ones to the event register and zero to the mask register leaves no event pending and `irq` at 0.
- R9: After reset all registers read 0, `pad_oe` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pad_in | input | 32 | Pin input values, bit n is line n |
| pad_out | output | 32 | Pin output values, bit n is line n |
| pad_oe | output | 32 | Pin output enables, bit n is line n |
| irq | output | 1 | Interrupt, high while a masked event is pending |

## Verification
Some properties are checked by assertions on every cycle:
- a detected edge always lands in the event register;
- a clearing write without a coinciding edge always empties its bits;
- event bits stay set until cleared;
- a rising transition never sets the event of a falling-only line;
- `irq` never rises with an empty mask;
- the all-ones acknowledge leaves only fresh edges.

Other behaviour can only be shown by the bench's scenarios:
- the bit-reversed mapping between lines and register bits;
- the exact two-cycle and three-cycle latencies from a pin change;
- the open-drain pad encoding;
- input-enable gating;
- the collision case where an edge beats a clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Word index of each register (byte address bits [4:2])
  typedef enum logic [2:0] {
    IDX_DIR = 3'd0,
    IDX_ODR = 3'd1,
    IDX_DAT = 3'd2,
    IDX_EVT = 3'd3,
    IDX_MSK = 3'd4,
    IDX_CTL = 3'd5,
    IDX_IBE = 3'd6
  } reg_idx_e;

  // One-bit edge qualifier: falling only, or any change
  function automatic logic edge_hit(input logic prev, input logic cur, input logic fall_only);
    return fall_only ? (prev & ~cur) : (prev ^ cur);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] samp,
  input  logic [WIDTH-1:0] fall_only,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] evt,
  output logic [WIDTH-1:0] edge_vec
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] evt_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_edge
    assign edge_vec[g] = gpio_pkg::edge_hit(prev_q[g], samp[g], fall_only[g]);
  end

  // A new edge overrides a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= samp;
      evt_q  <= (evt_q & ~clr) | edge_vec;
    end
  end

  assign evt = evt_q;

  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_vec != '0) |=> ((evt_q & $past(edge_vec)) == $past(edge_vec))); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~edge_vec) != '0) |=> ((evt_q & $past(clr & ~edge_vec)) == '0)); // R7
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q != '0) |=> (($past(evt_q) & ~$past(clr) & ~evt_q) == '0)); // R7
  AST_FALL_ONLY_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_only & samp & ~prev_q) != '0) |=>
      ((evt_q & ~$past(evt_q) & $past(fall_only & samp & ~prev_q)) == '0)); // R6

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic                 irq
);
  import gpio_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 2;

  // Line n <-> register bit NUM_LINES-1-n
  function automatic logic [NUM_LINES-1:0] mirror(input logic [NUM_LINES-1:0] v);
    logic [NUM_LINES-1:0] r;
    for (int i = 0; i < NUM_LINES; i++) r[i] = v[NUM_LINES-1-i];
    return r;
  endfunction

  logic [IDX_W-1:0]     idx;
  logic                 aligned;
  logic                 wr_sel;
  logic                 wr_dir, wr_odr, wr_dat, wr_evt, wr_msk, wr_ctl, wr_ibe;
  logic [NUM_LINES-1:0] dir_q, odr_q, dat_q, msk_q, ctl_q, ibe_q;
  logic [NUM_LINES-1:0] samp_bits, evt_bits, edge_bits, clr_bits;
  logic [NUM_LINES-1:0] data_view, oe_bits, out_bits;

  assign idx     = reg_addr[ADDR_W-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign wr_sel  = reg_we && aligned;
  assign wr_dir  = wr_sel && (idx == IDX_W'(IDX_DIR));
  assign wr_odr  = wr_sel && (idx == IDX_W'(IDX_ODR));
  assign wr_dat  = wr_sel && (idx == IDX_W'(IDX_DAT));
  assign wr_evt  = wr_sel && (idx == IDX_W'(IDX_EVT));
  assign wr_msk  = wr_sel && (idx == IDX_W'(IDX_MSK));
  assign wr_ctl  = wr_sel && (idx == IDX_W'(IDX_CTL));
  assign wr_ibe  = wr_sel && (idx == IDX_W'(IDX_IBE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
      ibe_q <= '0;
    end else begin
      if (wr_dir) dir_q <= reg_wdata;
      if (wr_odr) odr_q <= reg_wdata;
      if (wr_dat) dat_q <= reg_wdata;
      if (wr_msk) msk_q <= reg_wdata;
      if (wr_ctl) ctl_q <= reg_wdata;
      if (wr_ibe) ibe_q <= reg_wdata;
    end
  end

  gpio_in_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mirror(pad_in)),
    .q     (samp_bits)
  );

  assign clr_bits = wr_evt ? reg_wdata : '0;

  gpio_evt_unit #(.WIDTH(NUM_LINES)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp      (samp_bits),
    .fall_only (ctl_q),
    .clr       (clr_bits),
    .evt       (evt_bits),
    .edge_vec  (edge_bits)
  );

  assign data_view = (dat_q & dir_q) | (samp_bits & ibe_q & ~dir_q);
  assign oe_bits   = dir_q & ~(odr_q & dat_q);
  assign out_bits  = dat_q & ~odr_q;
  assign pad_oe    = mirror(oe_bits);
  assign pad_out   = mirror(out_bits);
  assign irq       = |(evt_bits & msk_q);

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      case (idx)
        IDX_W'(IDX_DIR): reg_rdata = dir_q;
        IDX_W'(IDX_ODR): reg_rdata = odr_q;
        IDX_W'(IDX_DAT): reg_rdata = data_view;
        IDX_W'(IDX_EVT): reg_rdata = evt_bits;
        IDX_W'(IDX_MSK): reg_rdata = msk_q;
        IDX_W'(IDX_CTL): reg_rdata = ctl_q;
        IDX_W'(IDX_IBE): reg_rdata = ibe_q;
        default:         reg_rdata = '0;
      endcase
    end
  end

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msk_q != '0)); // R8
  AST_MASK_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msk && (reg_wdata == '0)) |=> !irq); // R8
  AST_ACK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && (reg_wdata == '1)) |=> (evt_bits == $past(edge_bits))); // R8
  AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~mirror(dir_q)) == '0); // R3

endmodule

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DAT = 5'h08, A_EVT = 5'h0C,
                         A_MSK = 5'h10, A_CTL = 5'h14, A_IBE = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [31:0] bit_of(input int line);
    return 32'h8000_0000 >> line;
  endfunction

  function automatic logic [31:0] swap(input logic [31:0] v);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) if (v[i]) r = r | bit_of(i);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] pats [3];
    pats[0] = 32'hA5A5_5A5A; pats[1] = 32'hFFFF_0000; pats[2] = 32'h1234_5678;

    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R9 reset state
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), v); chk("R9 reset read", v, 32'h0);
    end
    chk("R9 reset pad_oe", pad_oe, 32'h0);
    chk("R9 reset irq", {31'h0, irq}, 32'h0);

    // R2 readback and unmapped / misaligned addresses
    for (int p = 0; p < 3; p++) begin
      wr(A_DIR, pats[p]); wr(A_ODR, ~pats[p]); wr(A_MSK, pats[p] ^ 32'h0F0F_0F0F);
      wr(A_CTL, pats[p] + 1); wr(A_IBE, ~pats[p] + 7);
      rd(A_DIR, v); chk("R2 dir readback", v, pats[p]);
      rd(A_ODR, v); chk("R2 odr readback", v, ~pats[p]);
      rd(A_MSK, v); chk("R2 msk readback", v, pats[p] ^ 32'h0F0F_0F0F);
      rd(A_CTL, v); chk("R2 ctl readback", v, pats[p] + 1);
      rd(A_IBE, v); chk("R2 ibe readback", v, ~pats[p] + 7);
    end
    wr(5'h1C, 32'hFFFF_FFFF); rd(5'h1C, v); chk("R2 unmapped reads 0", v, 32'h0);
    wr(5'h01, 32'h0000_0001); rd(A_DIR, v); chk("R2 misaligned write ignored", v, pats[2]);
    rd(5'h01, v); chk("R2 misaligned read 0", v, 32'h0);
    wr(A_DIR, 0); wr(A_ODR, 0); wr(A_MSK, 0); wr(A_CTL, 0); wr(A_IBE, 0); wr(A_DAT, 0);

    // R1 / R3 line-to-bit mapping sweep
    for (int n = 0; n < 32; n++) begin
      wr(A_DIR, bit_of(n)); wr(A_DAT, bit_of(n));
      chk($sformatf("R1 R3 pad_oe line %0d", n), pad_oe, 32'h1 << n);
      chk($sformatf("R1 R3 pad_out line %0d", n), pad_out, 32'h1 << n);
    end

    // R4 open drain
    begin
      logic [31:0] eo, ee;
      wr(A_DIR, 32'hFFFF_FFFF); wr(A_ODR, 32'hFFFF_0000); wr(A_DAT, 32'h0F0F_0F0F);
      for (int n = 0; n < 32; n++) begin
        logic od, dv;
        od = (n < 16); dv = ((32'h0F0F_0F0F & bit_of(n)) != 0);
        eo[n] = od ? !dv : 1'b1;
        ee[n] = od ? 1'b0 : dv;
      end
      chk("R4 open-drain pad_oe", pad_oe, eo);
      chk("R4 open-drain pad_out", pad_out, ee);
      wr(A_ODR, 0);
    end

    // R5 data view and input latency
    begin
      logic [31:0] dirv, datv, ibev, pin, exp;
      dirv = 32'hFF00_FF00; datv = 32'hAAAA_5555; ibev = 32'h0FF0_0FF0; pin = 32'h3C3C_C3C3;
      wr(A_DIR, dirv); wr(A_DAT, datv); wr(A_IBE, ibev);
      exp = datv & dirv;
      rd(A_DAT, v); chk("R5 data before pins", v, exp);
      pad_in = pin;
      for (int n = 0; n < 32; n++)
        if ((dirv & bit_of(n)) == 0 && (ibev & bit_of(n)) != 0 && pin[n]) exp = exp | bit_of(n);
      wait_n(1); rd(A_DAT, v); chk("R5 data one edge later unchanged", v, datv & dirv);
      wait_n(1); rd(A_DAT, v); chk("R5 data after two edges", v, exp);
      pad_in = 0; wait_n(4);
      wr(A_EVT, 32'hFFFF_FFFF);
      wr(A_DIR, 0); wr(A_DAT, 0); wr(A_IBE, 0);
    end

    // R6 latency: event appears on third edge (input enables all off)
    wr(A_CTL, 0);
    @(negedge clk); pad_in = 32'h1 << 5;
    wait_n(2); rd(A_EVT, v); chk("R6 event not yet after two edges", v, 32'h0);
    wait_n(1); rd(A_EVT, v); chk("R6 event after three edges", v, bit_of(5));
    pad_in = 0; wait_n(4); wr(A_EVT, 32'hFFFF_FFFF);

    // R6 / R7 per-line sweep of edge modes and clearing
    for (int n = 0; n < 32; n++) begin
      wr(A_CTL, 0);
      pad_in = 32'h1 << n; wait_n(3);
      rd(A_EVT, v); chk($sformatf("R6 both-mode rise line %0d", n), v, bit_of(n));
      wr(A_EVT, bit_of(n)); rd(A_EVT, v); chk($sformatf("R7 clear line %0d", n), v, 32'h0);
      pad_in = 0; wait_n(3);
      rd(A_EVT, v); chk($sformatf("R6 both-mode fall line %0d", n), v, bit_of(n));
      wr(A_EVT, 32'hFFFF_FFFF);
      wr(A_CTL, 32'hFFFF_FFFF);
      pad_in = 32'h1 << n; wait_n(3);
      rd(A_EVT, v); chk($sformatf("R6 fall-only ignores rise line %0d", n), v, 32'h0);
      pad_in = 0; wait_n(3);
      rd(A_EVT, v); chk($sformatf("R6 fall-only fall line %0d", n), v, bit_of(n));
      wr(A_EVT, 32'hFFFF_FFFF);
    end

    // R7 zero writes and other-line writes leave events
    wr(A_CTL, 0);
    @(negedge clk); pad_in = 32'h1 << 9; wait_n(4);
    wr(A_EVT, 32'h0); rd(A_EVT, v); chk("R7 write zero keeps event", v, bit_of(9));
    wr(A_EVT, ~bit_of(9)); rd(A_EVT, v); chk("R7 other bits keep event", v, bit_of(9));
    // R7 collision: clear in the cycle the next edge is detected
    @(negedge clk); pad_in = 0;
    @(negedge clk);
    wr(A_EVT, bit_of(9));
    rd(A_EVT, v); chk("R7 edge wins over clear", v, bit_of(9));
    wr(A_EVT, bit_of(9)); rd(A_EVT, v); chk("R7 clear without edge", v, 32'h0);

    // R8 interrupt masking
    @(negedge clk); pad_in = (32'h1 << 3) | (32'h1 << 17); wait_n(4);
    wr(A_MSK, 0); chk("R8 irq masked off", {31'h0, irq}, 32'h0);
    wr(A_MSK, bit_of(17)); chk("R8 irq line 17", {31'h0, irq}, 32'h1);
    wr(A_EVT, bit_of(17)); chk("R8 irq after ack", {31'h0, irq}, 32'h0);
    wr(A_MSK, 32'hFFFF_FFFF); chk("R8 irq line 3 all mask", {31'h0, irq}, 32'h1);
    wr(A_EVT, 32'hFFFF_FFFF); wr(A_MSK, 0);
    rd(A_EVT, v); chk("R8 ack-all events", v, 32'h0);
    chk("R8 ack-all irq", {31'h0, irq}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule